// File: doc/BRIEF.md
# Debounced Trigger Interrupt Arbiter

This block sits between four active-low trigger pins, which idle high, and a sequencer that runs voice programs. It filters each pin through a settle counter, turns every accepted change of level into a falling-edge or rising-edge event, and keeps that event as a pending request if its enable bit is set. Two further sources also compete for the sequencer: a power-on start request, raised once by an internal timer after reset and also available as an input pulse, and a software jump request.

Every cycle in which anything is pending, the block issues the single highest-ranked request as a one-cycle strobe with its vector number, and clears that pending bit. Requests that lose stay pending and go out on later cycles, one per cycle, in rank order. The settle length is chosen per cycle by a select input. The two lengths, the power-on delay and the pin count are parameters given in clock cycles.

Top module: `trig_prio_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_valid` and `jump_ack` are 0, and no request is pending.
- R2: A pin level is accepted only after the synchronised input has differed from the accepted level for the full settle count; a pulse shorter than the count produces no request. With the pin changed just before a clock edge, `irq_valid` rises after edge number count+4.
- R3: `long_deb`=1 selects the long count `LONG_CYC`; `long_deb`=0 selects the short count `SHORT_CYC`.
- R4: Pin index i (0..3) in `trig_n` has a falling vector of 0, 1, 8 and 9 and a rising vector of 4, 5, 12 and 13 for i = 0, 1, 2 and 3 in that order.
- R5: Pins 0 and 1 are enabled by `en_lo` and pins 2 and 3 by `en_hi`: in each register, bit 0 and bit 1 enable the falling edge of the lower and the higher pin of the pair, and bit 4 and bit 5 enable their rising edges; other bits have no effect. An edge detected while its bit is 0 is dropped and is not issued when the bit is set later.
- R6: Rank from highest to lowest: power-on start, pin0 fall, pin0 rise, pin1 fall, pin1 rise, pin2 fall, pin2 rise, pin3 fall, pin3 rise, jump.
- R7: When several requests are pending, exactly one is issued per cycle and the others stay pending until issued.
- R8: The power-on start request is raised once, `POI_DELAY` cycles after reset is released, or the cycle after a `poi_req` pulse, and issues vector 32.
- R9: A `jump_req` pulse is issued with vector code 63 and `jump_ack` high in the same cycle as `irq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n | input | 4 | Trigger pins, active low, idle high |
| long_deb | input | 1 | Settle length select: 1 long, 0 short |
| en_lo | input | 8 | Edge enables for pins 0 and 1 |
| en_hi | input | 8 | Edge enables for pins 2 and 3 |
| poi_req | input | 1 | Power-on start request pulse |
| jump_req | input | 1 | Software jump request pulse |
| irq_valid | output | 1 | One-cycle strobe: a request is issued |
| irq_vec | output | 6 | Vector number of the issued request |
| jump_ack | output | 1 | Strobe: the issued request is the jump |

## Verification
A settle counter that is off by one or a synchroniser stage too many shows up as a strobe one cycle early or late after a pin change, so the bench measures the exact latency for both settle lengths. A pending bit that is not cleared appears as a repeated vector on the next cycle, and one that is lost or cleared in the wrong place appears as a missing vector in a burst of simultaneous edges; both show within a few cycles of the burst. A wrong enable bit position is seen either as an edge that never gives a strobe or as a dropped edge that is issued later once its enable is set.

// File: rtl/trig_prio_pkg.sv
package trig_prio_pkg;

    localparam int NPIN   = 4;
    localparam int NSRC   = 2 * NPIN + 2;
    localparam int VEC_W  = 6;
    localparam logic [VEC_W-1:0] POI_VEC  = 6'd32;
    localparam logic [VEC_W-1:0] JUMP_VEC = 6'd63;

    // slot index in the pending vector; lower index wins
    typedef enum logic [3:0] {
        SRC_POI  = 4'd0,
        SRC_P0F  = 4'd1,
        SRC_P0R  = 4'd2,
        SRC_P1F  = 4'd3,
        SRC_P1R  = 4'd4,
        SRC_P2F  = 4'd5,
        SRC_P2R  = 4'd6,
        SRC_P3F  = 4'd7,
        SRC_P3R  = 4'd8,
        SRC_JUMP = 4'd9
    } src_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic             jump;
    } issue_t;

    // vector base of a pin's falling edge; rising adds 4
    function automatic logic [VEC_W-1:0] pin_base(input int pin);
        logic [VEC_W-1:0] b;
        b = VEC_W'(pin % 2);
        if (pin >= 2) b = b + 6'd8;
        return b;
    endfunction

    function automatic logic [VEC_W-1:0] slot_vector(input int slot);
        if (slot == int'(SRC_POI))  return POI_VEC;
        if (slot == int'(SRC_JUMP)) return JUMP_VEC;
        return pin_base((slot - 1) / 2) + (((slot - 1) % 2 == 1) ? 6'd4 : 6'd0);
    endfunction

endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic long_sel,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int CW = $clog2(LONG_CYC + 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            level_q <= 1'b1;
            cnt_q   <= '0;
            fall_ev <= 1'b0;
            rise_ev <= 1'b0;
        end else begin
            sync_q  <= {sync_q[0], pin_n};
            fall_ev <= 1'b0;
            rise_ev <= 1'b0;
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= limit) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
                rise_ev <= sync_q[1];
                fall_ev <= ~sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> (level_q == $past(sync_q[1])));

    // R2
    ev_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fall_ev && rise_ev));

endmodule

// File: rtl/poi_timer.sv
module poi_timer #(
    parameter int POI_DELAY = 480000
) (
    input  logic clk,
    input  logic rst,
    output logic fire
);
    localparam int TW = $clog2(POI_DELAY + 1);

    logic [TW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!done_q) begin
                if (cnt_q == TW'(POI_DELAY - 1)) begin
                    done_q <= 1'b1;
                    fire   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8
    poi_once_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import trig_prio_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    output logic [NSRC-1:0]  grant,
    output issue_t           pick
);
    always_comb begin
        grant      = '0;
        pick.valid = 1'b0;
        pick.vec   = '0;
        pick.jump  = 1'b0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (pend[s]) begin
                grant      = '0;
                grant[s]   = 1'b1;
                pick.valid = 1'b1;
                pick.vec   = slot_vector(s);
                pick.jump  = (s == int'(SRC_JUMP));
            end
        end
    end

    // R7
    grant_onehot_chk: assert final ($onehot0(grant));

endmodule

// File: rtl/trig_prio_ctrl.sv
module trig_prio_ctrl
    import trig_prio_pkg::*;
#(
    parameter int SHORT_CYC = 4800,
    parameter int LONG_CYC  = 150000,
    parameter int POI_DELAY = 480000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  trig_n,
    input  logic             long_deb,
    input  logic [7:0]       en_lo,
    input  logic [7:0]       en_hi,
    input  logic             poi_req,
    input  logic             jump_req,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec,
    output logic             jump_ack
);
    logic [NPIN-1:0] fall_ev, rise_ev;
    logic [NSRC-1:0] pend_q, new_req, grant;
    logic            poi_fire;
    issue_t          pick;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [7:0] en_reg;
        assign en_reg = (p < 2) ? en_lo : en_hi;

        trig_debounce #(
            .SHORT_CYC (SHORT_CYC),
            .LONG_CYC  (LONG_CYC)
        ) u_deb (
            .clk      (clk),
            .rst      (rst),
            .pin_n    (trig_n[p]),
            .long_sel (long_deb),
            .fall_ev  (fall_ev[p]),
            .rise_ev  (rise_ev[p])
        );

        // edges whose enable is clear are dropped here, never latched
        assign new_req[1 + 2*p] = fall_ev[p] & en_reg[p % 2];
        assign new_req[2 + 2*p] = rise_ev[p] & en_reg[4 + (p % 2)];
    end

    poi_timer #(.POI_DELAY(POI_DELAY)) u_poi (
        .clk  (clk),
        .rst  (rst),
        .fire (poi_fire)
    );

    assign new_req[SRC_POI]  = poi_fire | poi_req;
    assign new_req[SRC_JUMP] = jump_req;

    prio_pick u_pick (
        .pend  (pend_q),
        .grant (grant),
        .pick  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            irq_valid <= 1'b0;
            irq_vec   <= '0;
            jump_ack  <= 1'b0;
        end else begin
            pend_q    <= (pend_q & ~grant) | new_req;
            irq_valid <= pick.valid;
            irq_vec   <= pick.vec;
            jump_ack  <= pick.jump;
        end
    end

    // R7
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend_q) + 1) >= $past($countones(pend_q)));

    // R7
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(pend_q != '0));

    // R9
    jump_code_chk: assert property (@(posedge clk) disable iff (rst)
        jump_ack |-> (irq_valid && irq_vec == JUMP_VEC));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_valid && !jump_ack));

endmodule

// File: tb/tb_trig_prio_ctrl.sv
module tb_trig_prio_ctrl;
    import trig_prio_pkg::*;

    localparam int SHORT = 4;
    localparam int LONG  = 12;
    localparam int PDLY  = 20;

    logic             clk = 1'b0;
    logic             rst;
    logic [NPIN-1:0]  trig_n;
    logic             long_deb;
    logic [7:0]       en_lo, en_hi;
    logic             poi_req, jump_req;
    logic             irq_valid;
    logic [VEC_W-1:0] irq_vec;
    logic             jump_ack;

    int checks = 0;
    int bad    = 0;
    bit closed = 0;

    always #2 clk = ~clk;

    trig_prio_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .POI_DELAY(PDLY)) dut (
        .clk(clk), .rst(rst), .trig_n(trig_n), .long_deb(long_deb),
        .en_lo(en_lo), .en_hi(en_hi), .poi_req(poi_req), .jump_req(jump_req),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .jump_ack(jump_ack)
    );

    // {pin index, new level, expected vector}
    localparam logic [8:0] TBL [8] = '{
        {2'd0, 1'b0, 6'd0},  {2'd0, 1'b1, 6'd4},
        {2'd1, 1'b0, 6'd1},  {2'd1, 1'b1, 6'd5},
        {2'd2, 1'b0, 6'd8},  {2'd2, 1'b1, 6'd12},
        {2'd3, 1'b0, 6'd9},  {2'd3, 1'b1, 6'd13}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!closed) begin
            closed = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // wait for one strobe; lat>0 demands that exact number of edges
    task automatic expect_irq(input int vec, input int lat, input int maxw,
                              input bit jmp, input string req);
        bit seen = 0;
        int n = 0;
        for (int k = 1; k <= maxw && !seen; k++) begin
            @(posedge clk); #1;
            if (irq_valid) begin seen = 1; n = k; end
        end
        check(seen, req, 0, 1);
        if (seen) begin
            check(irq_vec == VEC_W'(vec), req, irq_vec, vec);
            check(jump_ack == jmp, {req, " ack"}, jump_ack, jmp);
            if (lat > 0) check(n == lat, {req, " latency"}, n, lat);
        end
    endtask

    task automatic expect_quiet(input int cyc, input string req);
        int hits = 0;
        for (int k = 0; k < cyc; k++) begin
            @(posedge clk); #1;
            if (irq_valid) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        rst = 1; trig_n = '1; long_deb = 0; en_lo = 8'h33; en_hi = 8'h33;
        poi_req = 0; jump_req = 0;
        repeat (3) @(posedge clk); #1;
        // R1 reset state
        check(!irq_valid && !jump_ack, "R1 reset", irq_valid, 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check(!irq_valid, "R1 after reset", irq_valid, 0);

        // R8 power-on start once after the delay
        expect_irq(32, 0, PDLY + 10, 0, "R8 poi");
        expect_quiet(3 * PDLY, "R8 poi once");

        // R4 vectors and R2 exact latency, walked from the table
        foreach (TBL[i]) begin
            @(negedge clk);
            trig_n[TBL[i][8:7]] = TBL[i][6];
            expect_irq(int'(TBL[i][5:0]), SHORT + 4, 40, 0, "R4 table");
            expect_quiet(3, "R4 single");
        end

        // R2 glitch shorter than the count
        @(negedge clk); trig_n[1] = 1'b0;
        repeat (SHORT - 1) @(negedge clk);
        trig_n[1] = 1'b1;
        expect_quiet(30, "R2 glitch");

        // R3 long count
        @(negedge clk); long_deb = 1; trig_n[2] = 1'b0;
        expect_irq(8, LONG + 4, 60, 0, "R3 long");
        @(negedge clk); trig_n[2] = 1'b1;
        expect_irq(12, LONG + 4, 60, 0, "R3 long rise");
        @(negedge clk); long_deb = 0;

        // R5 disabled edge dropped; don't-care bits set do not enable
        @(negedge clk); en_lo = 8'hCC; trig_n[0] = 1'b0;
        expect_quiet(SHORT + 12, "R5 disabled");
        @(negedge clk); en_lo = 8'h33;
        expect_quiet(10, "R5 dropped");
        @(negedge clk); trig_n[0] = 1'b1;
        expect_irq(4, SHORT + 4, 40, 0, "R5 rise enabled");

        // R5 rise disabled on pin3 only
        @(negedge clk); en_hi = 8'h13; trig_n[3] = 1'b0;
        expect_irq(9, SHORT + 4, 40, 0, "R5 pin3 fall");
        @(negedge clk); trig_n[3] = 1'b1;
        expect_quiet(SHORT + 12, "R5 pin3 rise off");
        @(negedge clk); en_hi = 8'h33;

        // R6 R7 simultaneous falls then rises
        @(negedge clk); trig_n = 4'b0000;
        expect_irq(0, SHORT + 4, 40, 0, "R6 burst first");
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd1, "R7 burst 2", irq_vec, 1);
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd8, "R7 burst 3", irq_vec, 8);
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd9, "R7 burst 4", irq_vec, 9);
        expect_quiet(4, "R7 burst end");
        @(negedge clk); trig_n = 4'b1111;
        expect_irq(4, SHORT + 4, 40, 0, "R6 rise first");
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd5, "R7 rise 2", irq_vec, 5);
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd12, "R7 rise 3", irq_vec, 12);
        @(posedge clk); #1; check(irq_valid && irq_vec == 6'd13, "R7 rise 4", irq_vec, 13);

        // R6 R8 R9 start request beats jump
        @(negedge clk); poi_req = 1; jump_req = 1;
        @(negedge clk); poi_req = 0; jump_req = 0;
        #1; check(!irq_valid, "R8 req timing", irq_valid, 0);
        @(posedge clk); #1;
        check(irq_valid && irq_vec == 6'd32 && !jump_ack, "R6 poi over jump", irq_vec, 32);
        @(posedge clk); #1;
        check(irq_valid && irq_vec == 6'd63 && jump_ack, "R9 jump second", irq_vec, 63);

        // R9 jump alone
        @(negedge clk); jump_req = 1;
        @(negedge clk); jump_req = 0;
        expect_irq(63, 1, 5, 1, "R9 jump");
        expect_quiet(5, "R9 single");

        // R1 reset clears pending
        @(negedge clk); jump_req = 1;
        @(negedge clk); jump_req = 0; rst = 1;
        @(negedge clk); rst = 0;
        expect_quiet(PDLY - 2, "R1 pending cleared");

        finish_up();
    end

endmodule